// File: doc/BRIEF.md
# Routed Level-Interrupt Controller

This block collects nine level-sensitive interrupt sources and presents them to a host interrupt controller on three request lines. Each source is first brought into the clock domain by a two-stage synchroniser. It is then corrected for its active level, so that a logic 1 always means "requesting". Some sources have a fixed active level. The others take theirs from a software-written polarity register.

Every request line has its own 32-bit control word. The low nine bits form an enable mask for that line. Bits 24:16 hold one sticky pending flag per source, and software clears a flag by writing 1 to it. A line requests service while any source that is both pending and enabled on that line exists. All pending flags update together, so when several sources are active at once, the handler reads them all in one access and services the highest-numbered one first.

Software reaches the block through a word-addressed register port with separate read and write strobes. Read data is registered.

Top module: `irq_route_ctl`

## Requirements
- R1: After reset, every enable bit and every pending bit is 0, all request outputs are 0, and the polarity register reads 0x000001FF.
- R2: Word address 0 holds the polarity register in bits 8:0. It is read and written as a whole word, and read data appears on `rdata` one clock after the cycle in which `rd_en` is high.
- R3: Word address 1+n (n = 0..2) holds the control word of request line n. Bits 8:0 of that word are read/write enables, and bit k lets source k drive that line.
- R4: Bits 24:16 of a line word show pending sources, with bit 16+k standing for source k. Writing 1 to bit 16+k clears that flag on that line only. Writing 0 leaves the flag unchanged.
- R5: A pending flag is set on every cycle in which its corrected source is active, and it stays set after the source goes inactive until it is cleared. When a set and a clear land in the same cycle, the set wins.
- R6: For sources 0 and 3 to 7, a polarity bit of 1 means the source is active high and a polarity bit of 0 means it is active low.
- R7: Sources 1 and 8 are always active high and source 2 is always active low. Their polarity bits have no effect.
- R8: Request output n is registered and equals the OR, over all sources, of pending AND enable on line n. A line whose enables are all 0 never requests.
- R9: Several pending flags can be set together, and all of them are visible in a single read.
- R10: Bits 31:25 and 15:9 of every register read as 0, and writes to them are ignored.
- R11: A source level change applied before clock edge k is visible in pending after edge k+2 and on the request output after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 9 | Asynchronous interrupt source levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address (0 polarity, 1..3 lines) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_req | output | 3 | Request lines toward the host controller |

## Verification
The hardest case to reach is a clear that arrives while its source is still active, where the clear and the set hit the same flag in the same edge. The stimulus holds a fixed active-high source asserted, writes the clear for its flag, and then reads the line back. The flag and the request must still be present. The fixed-polarity sources are covered by flipping the whole polarity register while their inputs sit at the inactive level, and confirming that no pending flag appears.

// File: rtl/irq_route_pkg.sv
// Shared constants for the routed level-interrupt controller.
// Assumes nine sources, three request lines and 32-bit register words.
package irq_route_pkg;
    localparam int NSRC      = 9;
    localparam int NLINE     = 3;
    localparam int DW        = 32;
    localparam int PEND_LSB  = 16;
    // Sources with a fixed active level, and that level.
    localparam logic [NSRC-1:0] FIXED_MASK = 9'b1_0000_0110;
    localparam logic [NSRC-1:0] FIXED_LVL  = 9'b1_0000_0010;
    // Reset value of the polarity register (all active high).
    localparam logic [NSRC-1:0] POL_RST    = 9'b1_1111_1111;
endpackage

// File: rtl/irq_src_cond.sv
// Source conditioning: two-flop synchroniser per source followed by
// polarity correction. Output bit is 1 when the source requests.
// Assumes src_i may change at any time; flops reset to the idle level.
module irq_src_cond #(
    parameter int              NSRC       = 9,
    parameter logic [NSRC-1:0] FIXED_MASK = '0,
    parameter logic [NSRC-1:0] FIXED_LVL  = '0,
    parameter logic [NSRC-1:0] SYNC_RST   = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] pol_i,
    output logic [NSRC-1:0] active_o
);
    logic [NSRC-1:0] s1_q;
    logic [NSRC-1:0] s2_q;

    // Two-stage synchroniser for every source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= SYNC_RST;
            s2_q <= SYNC_RST;
        end else begin
            s1_q <= src_i;
            s2_q <= s1_q;
        end
    end

    // Pick fixed or programmable level per source and normalise.
    for (genvar i = 0; i < NSRC; i++) begin : g_pol
        if (FIXED_MASK[i]) begin : g_fixed
            assign active_o[i] = FIXED_LVL[i] ? s2_q[i] : ~s2_q[i];
        end else begin : g_prog
            assign active_o[i] = pol_i[i] ? s2_q[i] : ~s2_q[i];
        end
    end

    AST_FIXED_POL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(s2_q) |-> $stable(active_o & FIXED_MASK)); // R7
endmodule

// File: rtl/irq_line_ctl.sv
// One request line: enable mask, sticky pending flags (set wins over
// write-1-clear) and a registered request output.
// Assumes en_wr_i and clr_i are already qualified by the address decode.
module irq_line_ctl #(
    parameter int NSRC = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr_i,
    input  logic [NSRC-1:0] en_data_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] active_i,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] pend_o,
    output logic            req_o
);
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend_q;
    logic            req_q;

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= en_data_i;
    end

    // Pending flags: clear by write-1, then re-set by active sources.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | active_i;
    end

    // Registered request: any enabled pending source.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |(pend_q & en_q);
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign req_o  = req_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(active_i)) == $past(active_i))); // R5
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !req_q); // R8
endmodule

// File: rtl/irq_route_ctl.sv
// Top: register decode, polarity register, registered read mux, and one
// irq_line_ctl per request line. Word-addressed; whole-word accesses.
// Assumes wr_en and rd_en are single-cycle strobes in the clk domain.
module irq_route_ctl
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = $clog2(NLINE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NLINE-1:0]  irq_req
);
    // Idle level of each source at reset, so no flag appears after reset.
    localparam logic [NSRC-1:0] SYNC_RST =
        ~((FIXED_MASK & FIXED_LVL) | (~FIXED_MASK & POL_RST));

    logic [NSRC-1:0] pol_q;
    logic [NSRC-1:0] active;
    logic [NSRC-1:0] en_w   [NLINE];
    logic [NSRC-1:0] pend_w [NLINE];
    logic [DW-1:0]   rd_next;
    logic [DW-1:0]   rdata_q;
    logic            unused_wbits;

    assign unused_wbits = ^{wdata[DW-1:PEND_LSB+NSRC], wdata[PEND_LSB-1:NSRC]};

    // Polarity register at word 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pol_q <= POL_RST;
        else if (wr_en && addr == '0)       pol_q <= wdata[NSRC-1:0];
    end

    irq_src_cond #(
        .NSRC(NSRC), .FIXED_MASK(FIXED_MASK),
        .FIXED_LVL(FIXED_LVL), .SYNC_RST(SYNC_RST)
    ) u_cond (
        .clk(clk), .rst_n(rst_n), .src_i(src_in),
        .pol_i(pol_q), .active_o(active)
    );

    for (genvar n = 0; n < NLINE; n++) begin : g_line
        logic hit;
        assign hit = wr_en && (addr == ADDR_W'(n + 1));
        irq_line_ctl #(.NSRC(NSRC)) u_line (
            .clk(clk), .rst_n(rst_n),
            .en_wr_i(hit),
            .en_data_i(wdata[NSRC-1:0]),
            .clr_i(hit ? wdata[PEND_LSB +: NSRC] : '0),
            .active_i(active),
            .en_o(en_w[n]),
            .pend_o(pend_w[n]),
            .req_o(irq_req[n])
        );
    end

    // Read mux: select the addressed word, unused bits stay zero.
    always_comb begin
        rd_next = '0;
        if (addr == '0) rd_next[NSRC-1:0] = pol_q;
        for (int k = 0; k < NLINE; k++) begin
            if (addr == ADDR_W'(k + 1)) begin
                rd_next[NSRC-1:0]          = en_w[k];
                rd_next[PEND_LSB +: NSRC]  = pend_w[k];
            end
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    assign rdata = rdata_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[DW-1:PEND_LSB+NSRC] == '0) && (rdata[PEND_LSB-1:NSRC] == '0)); // R10
endmodule

// File: tb/irq_route_ctl_tb.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and
// compares them when the registered read data appears.
module irq_route_ctl_tb;
    localparam int CLK_T = 10;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  src_in = 9'h004;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq_req;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic rd_seen = 1'b0;
    bit   done = 0;

    always #(CLK_T/2) clk = ~clk;

    irq_route_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_req(irq_req)
    );

    // Monitor: note accepted reads, compare at the following falling edge.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: got %08h exp none", rdata);
            end else begin
                e = sb_q.pop_front();
                if (rdata !== e.exp) begin
                    n_bad++;
                    $display("FAIL %s: rdata got %08h exp %08h", e.tag, rdata, e.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        n_cmp++;
        if (irq_req !== e) begin
            n_bad++;
            $display("FAIL %s: irq_req got %b exp %b", tag, irq_req, e);
        end
    endtask

    initial begin
        #(CLK_T * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk_irq(3'b000, "R1 reset irq");
        rd(2'd0, 32'h0000_01FF, "R1 polarity reset");
        rd(2'd1, 32'h0, "R1 line0 reset");
        rd(2'd2, 32'h0, "R1 line1 reset");
        rd(2'd3, 32'h0, "R1 line2 reset");
        // R2 / R10 polarity register and reserved bits
        wr(2'd0, 32'hFE00_FFFF);
        rd(2'd0, 32'h0000_01FF, "R2 R10 polarity rsvd");
        // R3 enables, R10 reserved bits on a line word
        wr(2'd1, 32'h0000_0155);
        wr(2'd2, 32'h0000_00AA);
        wr(2'd3, 32'hFE00_FFFF);
        rd(2'd1, 32'h0000_0155, "R3 line0 en");
        rd(2'd2, 32'h0000_00AA, "R3 line1 en");
        rd(2'd3, 32'h0000_01FF, "R3 R10 line2 en");
        wr(2'd1, 32'h0000_0001);
        wr(2'd2, 32'h0000_0100);
        wr(2'd3, 32'h0000_0000);
        // R11 latency and R8 request on src0
        src_in[0] = 1'b1;
        tick(3);
        chk_irq(3'b000, "R11 before request edge");
        tick(1);
        chk_irq(3'b001, "R11 R8 line0 request");
        rd(2'd1, 32'h0001_0001, "R9 line0 pending");
        rd(2'd2, 32'h0001_0100, "R8 line1 pending masked");
        chk_irq(3'b001, "R8 only enabled line");
        // R5 sticky after source drop
        src_in[0] = 1'b0;
        tick(4);
        chk_irq(3'b001, "R5 sticky irq");
        rd(2'd1, 32'h0001_0001, "R5 sticky pending");
        // R4 write-1-clear, per line
        wr(2'd1, 32'h0001_0001);
        tick(1);
        chk_irq(3'b000, "R4 cleared irq");
        rd(2'd1, 32'h0000_0001, "R4 line0 cleared");
        rd(2'd2, 32'h0001_0100, "R4 line1 untouched");
        wr(2'd2, 32'h0000_0100);
        rd(2'd2, 32'h0001_0100, "R4 write 0 no effect");
        wr(2'd2, 32'h01FF_0100);
        rd(2'd2, 32'h0000_0100, "R4 line1 cleared");
        // R5 set wins over clear, source 8 fixed high (R7)
        src_in[8] = 1'b1;
        tick(5);
        chk_irq(3'b010, "R7 R8 src8 request");
        wr(2'd2, 32'h0100_0100);
        tick(1);
        rd(2'd2, 32'h0100_0100, "R5 set wins");
        tick(2);
        chk_irq(3'b010, "R5 irq held");
        src_in[8] = 1'b0;
        tick(4);
        wr(2'd2, 32'h01FF_0100);
        tick(2);
        chk_irq(3'b000, "R5 released");
        rd(2'd2, 32'h0000_0100, "R5 line1 empty");
        // R6 active-low programmable source 3
        wr(2'd0, 32'h0000_01F7);
        wr(2'd3, 32'h0000_0008);
        tick(5);
        chk_irq(3'b100, "R6 active low src3");
        rd(2'd3, 32'h0109_0008, "R6 R9 line2 pending");
        src_in[3] = 1'b1;
        tick(4);
        wr(2'd3, 32'h01FF_0008);
        tick(2);
        chk_irq(3'b000, "R6 src3 idle high");
        rd(2'd3, 32'h0000_0008, "R6 line2 cleared");
        // R7 fixed polarity ignores the register
        src_in = 9'h0FD;
        tick(4);
        wr(2'd0, 32'h0000_0000);
        tick(4);
        wr(2'd1, 32'h01FF_0000);
        wr(2'd2, 32'h01FF_0000);
        wr(2'd3, 32'h01FF_0000);
        tick(1);
        rd(2'd0, 32'h0000_0000, "R2 polarity zero");
        rd(2'd1, 32'h0000_0000, "R7 fixed ignore pol0");
        wr(2'd0, 32'h0000_01FF);
        tick(4);
        rd(2'd1, 32'h00F9_0000, "R7 R9 fixed ignore pol1");
        src_in[2] = 1'b0;
        tick(4);
        rd(2'd2, 32'h00FD_0000, "R7 src2 active low");
        src_in[1] = 1'b1;
        tick(4);
        rd(2'd3, 32'h00FF_0000, "R7 R9 src1 active high");
        chk_irq(3'b000, "R8 all masked");
        tick(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule